// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small binary up-counter, by default four bits wide, meant to be chained into wider counters. All state changes happen on the rising edge of one clock. A synchronous clear, active low, takes precedence over everything else. Next comes a synchronous parallel load, also active low, which copies a data word into the counter. Counting is lowest in priority and needs two active-high enables together: one shared by every stage of a chain, and one rippled from stage to stage.

The terminal-count output is a plain combinational gate of the ripple enable and an all-ones match of the count. When it feeds the next stage's ripple enable, each higher stage advances on exactly the clock edge where every lower stage wraps. Because the clear is synchronous, a decoder on the count can drive the clear input to make a counter with a shorter modulus. The count then returns to zero on the edge after the decoded value appears.

Top module: `sync_count_cell`

## Requirements
- R1: The count output changes only at a rising clock edge. Input changes between edges leave it unchanged.
- R2: With clr_n low at a rising edge, the count becomes zero, whatever load_n, en_par, en_trk and din are.
- R3: With clr_n high and load_n low at a rising edge, the count takes the value of din, whatever en_par and en_trk are.
- R4: With clr_n and load_n both high and en_par and en_trk both high, the count goes up by one at the rising edge.
- R5: With clr_n and load_n both high and at least one of en_par or en_trk low, the count keeps its value across the edge.
- R6: carry_out is 1 exactly when en_trk is 1 and the count is all ones at WIDTH bits.
- R7: carry_out follows en_trk within the same clock cycle, with no register in between.
- R8: An enabled increment from all ones gives zero. No other output records the wrap.
- R9: If clr_n is driven low whenever the count equals a chosen value N, the count runs 0, 1, ..., N, 0, 1, ...
- R10: Stages that share clr_n, load_n and en_par, each taking a slice of the wide data word, with each carry_out wired to the next stage's en_trk, behave as one wide counter. The last carry_out marks the wide all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable shared by all stages of a chain |
| en_trk | input | 1 | Count enable rippled from the previous stage, also gates carry_out |
| din | input | WIDTH | Parallel load data |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal count: en_trk high and count all ones |

## Verification
The bench builds three instances at the default WIDTH of 4 and chains them into a 12-bit counter. This makes inter-stage carries visible: a single-stage wrap, a double-stage carry at 0x0FF, and a full wrap from 0xFFF with the final terminal count. A fourth instance at WIDTH 3 has an equality decode on its own count driving its clear. This gives the shortened modulus and a compare width other than four bits. Every chained edge is checked against a 12-bit reference with the same clear-load-count priority, including cycles where clear, load and both enables are active at once.

// File: rtl/sync_count_cell.sv
module sync_count_cell #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] TOP = '1;

  logic step;
  assign step = en_par && en_trk;

  always_ff @(posedge clk) begin
    if (!clr_n)       count <= '0;
    else if (!load_n) count <= din;
    else if (step)    count <= count + 1'b1;
  end

  assign carry_out = en_trk && (count == TOP);

endmodule

// File: rtl/sync_count_cell_chk.sv
module sync_count_cell_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] TOP = '1;

  logic armed = 1'b0;
  always @(posedge clk) if (!clr_n) armed <= 1'b1;

  // R2
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> count == '0);
  // R3
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> count == $past(din));
  // R4
  a_r4_increment: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && en_par && en_trk) |=> count == $past(count) + WIDTH'(1));
  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(count));
  // R6
  a_r6_tc_needs_trk: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (en_trk && count == TOP));
  a_r6_tc_at_top: assert property (@(posedge clk) disable iff (!armed)
    (en_trk && count == TOP) |-> carry_out);
  // R8
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!armed)
    (count == TOP && clr_n && load_n && en_par && en_trk) |=> count == '0);

endmodule

bind sync_count_cell sync_count_cell_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
  .en_trk(en_trk), .din(din), .count(count), .carry_out(carry_out)
);

// File: tb/tb_sync_count_cell.sv
module tb_sync_count_cell;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [11:0] din = '0;
  logic [3:0]  q0, q1, q2;
  logic        tc0, tc1, tc2;

  sync_count_cell #(.WIDTH(4)) dut   (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din[3:0]),  .count(q0), .carry_out(tc0));
  sync_count_cell #(.WIDTH(4)) u_mid (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(tc0),    .din(din[7:4]),  .count(q1), .carry_out(tc1));
  sync_count_cell #(.WIDTH(4)) u_top (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(tc1),    .din(din[11:8]), .count(q2), .carry_out(tc2));

  logic       kick_n = 1'b1;
  logic [2:0] mq;
  logic       mtc;
  logic       mod_clr_n;
  assign mod_clr_n = kick_n && (mq != 3'd5);
  sync_count_cell #(.WIDTH(3)) u_mod (.clk(clk), .clr_n(mod_clr_n), .load_n(1'b1), .en_par(1'b1),
    .en_trk(1'b1), .din(3'd0), .count(mq), .carry_out(mtc));

  typedef struct { logic [11:0] val; logic tc; string req; } item_t;
  item_t sb[$];

  int n_run = 0, n_fail = 0;
  logic [11:0] refv = '0;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [11:0] d, input string req);
    logic [11:0] nxt;
    item_t it;
    @(negedge clk);
    clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
    #1;
    check({4'h0, q2, q1, q0}, {4'h0, refv}, "R1 count steady between edges");
    check({15'h0, tc2}, {15'h0, t && (refv == 12'hFFF)}, "R7 carry follows en_trk same cycle");
    if (!c)           nxt = '0;
    else if (!l)      nxt = d;
    else if (p && t)  nxt = refv + 12'd1;
    else              nxt = refv;
    it.val = nxt; it.tc = t && (nxt == 12'hFFF); it.req = req;
    sb.push_back(it);
    refv = nxt;
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({4'h0, q2, q1, q0}, {4'h0, it.val}, it.req);
      check({15'h0, tc2}, {15'h0, it.tc}, {it.req, " / R6 R10 carry"});
    end
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R2 clear from unknown start, also the reset state
    step(0, 1, 1, 1, 12'h000, "R2 initial clear");
    refv = '0;
    step(1, 1, 0, 0, 12'h000, "R5 hold both enables low");
    step(0, 0, 1, 1, 12'hABC, "R2 clear beats load and enables");
    step(1, 0, 0, 0, 12'h5A3, "R3 load with enables low");
    step(1, 0, 1, 1, 12'h0FE, "R3 load with enables high");
    step(1, 1, 1, 1, 12'h777, "R4 increment");
    step(1, 1, 1, 1, 12'h777, "R4 R10 carry across two stages");
    step(1, 1, 0, 1, 12'h000, "R5 hold en_par low");
    step(1, 1, 1, 0, 12'h000, "R5 hold en_trk low");
    step(1, 0, 0, 0, 12'hFFD, "R3 load near top");
    step(1, 1, 1, 1, 12'h000, "R4 count");
    step(1, 1, 1, 1, 12'h000, "R6 reach all ones");
    step(1, 1, 0, 1, 12'h000, "R6 top held, carry high");
    step(1, 1, 0, 0, 12'h000, "R6 R7 en_trk low masks carry");
    step(1, 1, 1, 1, 12'h000, "R8 R10 wide wrap to zero");
    step(1, 1, 1, 1, 12'h000, "R4 after wrap");
    step(1, 0, 1, 0, 12'hEF0, "R3 load for long run");
    for (int i = 0; i < 400; i++) begin
      logic p, t, c, l;
      p = (i % 7) != 3;
      t = (i % 11) != 5;
      c = (i % 97) != 60;
      l = (i % 131) != 70;
      step(c, l, p, t, 12'(i * 37), "R10 chained run vs wide reference");
    end
    step(1, 0, 1, 1, 12'hFFF, "R3 load all ones");
    step(1, 1, 1, 1, 12'h000, "R8 wrap from all ones");
    @(posedge clk); #3;

    // R9 shortened modulus through decoded clear
    @(negedge clk); kick_n = 1'b0;
    @(negedge clk); kick_n = 1'b1;
    begin
      logic [2:0] e;
      e = 3'd0;
      for (int k = 0; k < 14; k++) begin
        check({13'h0, mq}, {13'h0, e}, "R9 modulus six sequence");
        check({15'h0, mtc}, {15'h0, (e == 3'd7)}, "R9 R6 no top at width 3");
        e = (e == 3'd5) ? 3'd0 : e + 3'd1;
        @(negedge clk);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule